// File: doc/BRIEF.md
# Dual-Port Synchronous Word Memory with Selectable Read Latency

This block is a true dual-port static memory of 36-bit words. Its two ports, left and right, each have their own select, read/write strobe, address, write data, read data and output enable. Both ports run from one shared clock. Each port can read or write any word on any cycle, including the word the other port is using. Every input is captured in a register on the rising clock edge, and the memory acts on those registered values.

Each word is made of four 9-bit byte lanes. The left port has a lane-select input, so it can write any subset of the lanes and leave the rest untouched. The right port always writes the full word. The static input `pipe_mode` sets the read latency for both ports. With flow-through output, the read data is produced combinationally from the registered address. With pipelined output, the read data passes through one more output register. A cycle in which a port is deselected powers that port down: its output enable drops and its data bus reads zero. In pipelined mode the first enabled read after a power-down reaches the outputs one cycle later than it would in flow-through mode. The depth is a parameter; the default is 1024 words and 16K is supported.

Top module: `dpr_sram`

## Requirements
- R1: After reset, both ports hold `*_oe` low and `*_rdata` at zero until a read has been registered.
- R2: Commands are sampled on the rising edge. `cs_n` low with `we` low is a read, `cs_n` low with `we` high is a write, and `cs_n` high is a deselect.
- R3: With `pipe_mode`=0, a read registered at edge k drives `*_oe` high and the addressed word on `*_rdata` from edge k until edge k+1.
- R4: With `pipe_mode`=1, a read registered at edge k drives its word and `*_oe` high from edge k+1 until edge k+2.
- R5: A deselect registered at edge k powers the port down in that read slot. `*_oe` is low and `*_rdata` is zero after edge k in flow-through mode, and after edge k+1 in pipelined mode. An enabled read brings the outputs back within the same latency.
- R6: A write cycle takes a read slot but produces no read: the port's outputs are disabled in that slot.
- R7: On the left port, `l_ben[i]`=1 writes lane i, which is bits 9i+8 down to 9i. Lanes whose select is 0 keep their contents. A left write with `l_ben`=0 changes nothing.
- R8: A right-port write always replaces the whole 36-bit word.
- R9: The two ports reach any address, including 0 and DEPTH-1, independently on the same cycle.
- R10: When both ports write the same address at the same edge, lanes selected by `l_ben` take the left data and all other lanes take the right data.
- R11: A read registered at the same edge as a write to the same address, from either port, returns the word as it was before that write.
- R12: A write registered at edge k is visible to any read registered at edge k+1 or later, in either output mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_mode | input | 1 | Static latency select: 0 flow-through, 1 pipelined |
| l_cs_n | input | 1 | Left port select, active low |
| l_we | input | 1 | Left port write strobe (1 = write) |
| l_ben | input | 4 | Left port byte-lane write selects |
| l_addr | input | AW | Left port word address |
| l_wdata | input | 36 | Left port write data |
| l_rdata | output | 36 | Left port read data, zero when disabled |
| l_oe | output | 1 | Left port output enable |
| r_cs_n | input | 1 | Right port select, active low |
| r_we | input | 1 | Right port write strobe (1 = write) |
| r_addr | input | AW | Right port word address |
| r_wdata | input | 36 | Right port write data |
| r_rdata | output | 36 | Right port read data, zero when disabled |
| r_oe | output | 1 | Right port output enable |

## Verification
The bench focuses on same-address collisions.

- **Dual write to one word.** If the right port's lanes were lost, the merged word would show stale lanes where right data belongs. If precedence were wrong, the right data would replace selected left lanes.
- **Read during write to the same word.** A memory that forwarded the new data would return the new word where the old one is expected.
- **Mode timing.** In pipelined mode, a design with the wrong latency would put data one slot early or late. One that kept the output enable across a deselect or a write cycle would show a live bus where it must be quiet.
- **Partial writes.** A zero-lane write or a one-lane write that touched other lanes would show up as changed lanes on a later read-back.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;

    // Expand per-lane write selects into a per-bit mask.
    function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] sel);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < LANES; i++) begin
            m[i*LANE_W +: LANE_W] = {LANE_W{sel[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/dpr_in_stage.sv
module dpr_in_stage
    import dpr_pkg::*;
#(
    parameter int AW       = 10,
    parameter bit BYTE_SEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we,
    input  logic [LANES-1:0]  sel,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              rd_q,
    output logic              wr_q,
    output logic [AW-1:0]     addr_q,
    output logic [WORD_W-1:0] wdata_q,
    output logic [WORD_W-1:0] wmask_q
);

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [AW-1:0]     addr;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] mask;
    } in_st_t;

    in_st_t st_d, st_q;
    logic [WORD_W-1:0] mask_in;

    generate
        if (BYTE_SEL) begin : g_lane_sel
            assign mask_in = lane_mask(sel);
        end else begin : g_full_word
            logic unused_sel;
            assign unused_sel = ^sel;
            assign mask_in    = '1;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.rd   = ~cs_n & ~we;
        st_d.wr   = ~cs_n &  we;
        st_d.addr = addr;
        st_d.data = wdata;
        st_d.mask = mask_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_q    = st_q.rd;
    assign wr_q    = st_q.wr;
    assign addr_q  = st_q.addr;
    assign wdata_q = st_q.data;
    assign wmask_q = st_q.mask;

endmodule

// File: rtl/dpr_array.sv
module dpr_array
    import dpr_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic              clk,
    input  logic              a_wr,
    input  logic [AW-1:0]     a_addr,
    input  logic [WORD_W-1:0] a_data,
    input  logic [WORD_W-1:0] a_mask,
    input  logic              b_wr,
    input  logic [AW-1:0]     b_addr,
    input  logic [WORD_W-1:0] b_data,
    input  logic [WORD_W-1:0] b_mask,
    output logic [WORD_W-1:0] a_rdata,
    output logic [WORD_W-1:0] b_rdata
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] a_word_d, b_word_d, both_word_d;
    logic              same_row_d;

    // Port a (left) has precedence on its selected lanes.
    always_comb begin
        a_rdata     = mem[a_addr];
        b_rdata     = mem[b_addr];
        same_row_d  = a_wr & b_wr & (a_addr == b_addr);
        a_word_d    = (a_rdata & ~a_mask) | (a_data & a_mask);
        b_word_d    = (b_rdata & ~b_mask) | (b_data & b_mask);
        both_word_d = (b_word_d & ~a_mask) | (a_data & a_mask);
    end

    always_ff @(posedge clk) begin
        if (b_wr && !same_row_d) begin
            mem[b_addr] <= b_word_d;
        end
        if (a_wr) begin
            mem[a_addr] <= same_row_d ? both_word_d : a_word_d;
        end
    end

endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage
    import dpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe,
    input  logic              rd_q,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] dout,
    output logic              oe
);

    typedef struct packed {
        logic              oe;
        logic [WORD_W-1:0] data;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.oe   = rd_q;
        st_d.data = rd_q ? rdata : st_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (pipe) begin
            oe   = st_q.oe;
            dout = st_q.oe ? st_q.data : '0;
        end else begin
            oe   = rd_q;
            dout = rd_q ? rdata : '0;
        end
    end

endmodule

// File: rtl/dpr_sram.sv
module dpr_sram
    import dpr_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              l_cs_n,
    input  logic              l_we,
    input  logic [LANES-1:0]  l_ben,
    input  logic [AW-1:0]     l_addr,
    input  logic [WORD_W-1:0] l_wdata,
    output logic [WORD_W-1:0] l_rdata,
    output logic              l_oe,
    input  logic              r_cs_n,
    input  logic              r_we,
    input  logic [AW-1:0]     r_addr,
    input  logic [WORD_W-1:0] r_wdata,
    output logic [WORD_W-1:0] r_rdata,
    output logic              r_oe
);

    logic              l_rd_q, l_wr_q, r_rd_q, r_wr_q;
    logic [AW-1:0]     l_addr_q, r_addr_q;
    logic [WORD_W-1:0] l_data_q, r_data_q, l_mask_q, r_mask_q;
    logic [WORD_W-1:0] l_word, r_word;

    dpr_in_stage #(.AW(AW), .BYTE_SEL(1'b1)) u_l_in (
        .clk(clk), .rst_n(rst_n), .cs_n(l_cs_n), .we(l_we), .sel(l_ben),
        .addr(l_addr), .wdata(l_wdata), .rd_q(l_rd_q), .wr_q(l_wr_q),
        .addr_q(l_addr_q), .wdata_q(l_data_q), .wmask_q(l_mask_q)
    );

    dpr_in_stage #(.AW(AW), .BYTE_SEL(1'b0)) u_r_in (
        .clk(clk), .rst_n(rst_n), .cs_n(r_cs_n), .we(r_we), .sel('0),
        .addr(r_addr), .wdata(r_wdata), .rd_q(r_rd_q), .wr_q(r_wr_q),
        .addr_q(r_addr_q), .wdata_q(r_data_q), .wmask_q(r_mask_q)
    );

    dpr_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk(clk),
        .a_wr(l_wr_q), .a_addr(l_addr_q), .a_data(l_data_q), .a_mask(l_mask_q),
        .b_wr(r_wr_q), .b_addr(r_addr_q), .b_data(r_data_q), .b_mask(r_mask_q),
        .a_rdata(l_word), .b_rdata(r_word)
    );

    dpr_out_stage u_l_out (
        .clk(clk), .rst_n(rst_n), .pipe(pipe_mode), .rd_q(l_rd_q),
        .rdata(l_word), .dout(l_rdata), .oe(l_oe)
    );

    dpr_out_stage u_r_out (
        .clk(clk), .rst_n(rst_n), .pipe(pipe_mode), .rd_q(r_rd_q),
        .rdata(r_word), .dout(r_rdata), .oe(r_oe)
    );

endmodule

// File: rtl/dpr_sram_chk.sv
module dpr_sram_chk
    import dpr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pipe_mode,
    input logic              l_cs_n,
    input logic              l_we,
    input logic [WORD_W-1:0] l_rdata,
    input logic              l_oe,
    input logic              r_cs_n,
    input logic              r_we,
    input logic [WORD_W-1:0] r_rdata,
    input logic              r_oe
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!l_oe && !r_oe));

    assert_left_flow_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && !l_cs_n && !l_we) |=> l_oe);

    assert_right_flow_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && !r_cs_n && !r_we) |=> r_oe);

    assert_left_pipe_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !l_cs_n && !l_we) |=> ##1 l_oe);

    assert_right_pipe_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !r_cs_n && !r_we) |=> ##1 r_oe);

    // R5 and R6: deselect or write leaves the read slot disabled
    assert_left_flow_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && (l_cs_n || l_we)) |=> !l_oe);

    assert_right_flow_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && (r_cs_n || r_we)) |=> !r_oe);

    assert_left_pipe_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && (l_cs_n || l_we)) |=> ##1 !l_oe);

    assert_right_pipe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && (r_cs_n || r_we)) |=> ##1 !r_oe);

    assert_left_bus_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !l_oe |-> (l_rdata == '0));

    assert_right_bus_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !r_oe |-> (r_rdata == '0));

endmodule

bind dpr_sram dpr_sram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .l_cs_n(l_cs_n), .l_we(l_we), .l_rdata(l_rdata), .l_oe(l_oe),
    .r_cs_n(r_cs_n), .r_we(r_we), .r_rdata(r_rdata), .r_oe(r_oe)
);

// File: tb/dpr_sram_test.sv
`timescale 1ns/1ps
module dpr_sram_test;
    import dpr_pkg::*;

    localparam int DEPTH = 1024;
    localparam int AW    = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pipe_mode = 1'b0;
    logic              l_cs_n = 1'b1, l_we = 1'b0;
    logic [3:0]        l_ben = '0;
    logic [AW-1:0]     l_addr = '0;
    logic [35:0]       l_wdata = '0;
    logic [35:0]       l_rdata;
    logic              l_oe;
    logic              r_cs_n = 1'b1, r_we = 1'b0;
    logic [AW-1:0]     r_addr = '0;
    logic [35:0]       r_wdata = '0;
    logic [35:0]       r_rdata;
    logic              r_oe;

    always #4 clk = ~clk;

    dpr_sram #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
        .l_cs_n(l_cs_n), .l_we(l_we), .l_ben(l_ben), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_oe(l_oe),
        .r_cs_n(r_cs_n), .r_we(r_we), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_oe(r_oe)
    );

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    logic [35:0] model [DEPTH];
    // read slot currently due and the one before it, per port
    bit          cur_l_rd, cur_r_rd, prv_l_rd, prv_r_rd;
    logic [35:0] cur_l_val, cur_r_val, prv_l_val, prv_r_val;

    // R7: lane i occupies bits 9i+8..9i
    function automatic logic [35:0] lanes_to_bits(input logic [3:0] b);
        logic [35:0] m = '0;
        for (int i = 0; i < 4; i++) if (b[i]) m[i*9 +: 9] = 9'h1FF;
        return m;
    endfunction

    function automatic int pick_addr();
        int idx = $urandom_range(0, 63);
        return (idx < 32) ? idx : DEPTH - 64 + idx;
    endfunction

    function automatic logic [35:0] rand_word();
        return {4'($urandom_range(0, 15)), 32'($urandom())};
    endfunction

    task automatic check_port(input string tag, input string side, input bit oe_got,
                              input logic [35:0] d_got, input bit oe_exp, input logic [35:0] d_exp);
        n_checks++;
        if (oe_got !== oe_exp || d_got !== d_exp) begin
            n_fails++;
            $display("FAIL %s %s port: oe=%0b data=%h expected oe=%0b data=%h",
                     tag, side, oe_got, d_got, oe_exp, d_exp);
        end
    endtask

    // Called at a falling edge; drives one command per port, then checks the slot due.
    task automatic step(input string tag,
                        input bit l_en, input bit l_w, input logic [3:0] lb, input int la, input logic [35:0] ld,
                        input bit r_en, input bit r_w, input int ra, input logic [35:0] rd);
        logic [35:0] lm, merged;
        l_cs_n = ~l_en; l_we = l_w; l_ben = lb; l_addr = AW'(la); l_wdata = ld;
        r_cs_n = ~r_en; r_we = r_w; r_addr = AW'(ra); r_wdata = rd;
        @(posedge clk);
        prv_l_rd = cur_l_rd; prv_l_val = cur_l_val;
        prv_r_rd = cur_r_rd; prv_r_val = cur_r_val;
        cur_l_rd = l_en && !l_w; cur_l_val = model[la];
        cur_r_rd = r_en && !r_w; cur_r_val = model[ra];
        lm = lanes_to_bits(lb);
        if (l_en && l_w && r_en && r_w && la == ra) begin
            merged = (rd & ~lm) | (ld & lm);
            model[la] = merged;
        end else begin
            if (r_en && r_w) model[ra] = rd;
            if (l_en && l_w) model[la] = (model[la] & ~lm) | (ld & lm);
        end
        @(negedge clk);
        if (pipe_mode) begin
            check_port(tag, "left",  l_oe, l_rdata, prv_l_rd, prv_l_rd ? prv_l_val : 36'h0);
            check_port(tag, "right", r_oe, r_rdata, prv_r_rd, prv_r_rd ? prv_r_val : 36'h0);
        end else begin
            check_port(tag, "left",  l_oe, l_rdata, cur_l_rd, cur_l_rd ? cur_l_val : 36'h0);
            check_port(tag, "right", r_oe, r_rdata, cur_r_rd, cur_r_rd ? cur_r_val : 36'h0);
        end
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 4'h0, 0, 36'h0, 0, 0, 0, 36'h0);
    endtask

    task automatic run_mode(input bit pm);
        string t;
        @(negedge clk);
        rst_n = 1'b0; pipe_mode = pm;
        l_cs_n = 1'b1; r_cs_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_l_rd = 0; cur_r_rd = 0; prv_l_rd = 0; prv_r_rd = 0;
        cur_l_val = '0; cur_r_val = '0; prv_l_val = '0; prv_r_val = '0;
        check_port("R1", "left",  l_oe, l_rdata, 1'b0, 36'h0);
        check_port("R1", "right", r_oe, r_rdata, 1'b0, 36'h0);
        idle("R1");
        // fill the address pool, both ports writing (R8, R9)
        for (int i = 0; i < 32; i++) begin
            step("R9", 1, 1, 4'hF, i, rand_word(), 1, 1, DEPTH - 32 + i, rand_word());
        end
        // R12: read back immediately after write, both ends of the array
        step("R12", 1, 0, 4'h0, DEPTH - 1, 36'h0, 1, 0, 0, 36'h0);
        // R7: partial lanes, then a zero-lane write
        step("R7", 1, 1, 4'b0101, 3, 36'hABCDE1234, 0, 0, 0, 36'h0);
        step("R7", 1, 0, 4'h0, 3, 36'h0, 1, 0, 3, 36'h0);
        step("R7", 1, 1, 4'b0000, 3, 36'hFFFFFFFFF, 0, 0, 0, 36'h0);
        step("R7", 1, 0, 4'h0, 3, 36'h0, 0, 0, 0, 36'h0);
        step("R7", 1, 1, 4'b1000, 4, 36'h000000000, 0, 0, 0, 36'h0);
        step("R7", 1, 0, 4'h0, 4, 36'h0, 0, 0, 0, 36'h0);
        // R8: right full-word write
        step("R8", 0, 0, 4'h0, 0, 36'h0, 1, 1, 6, 36'h123456789);
        step("R8", 1, 0, 4'h0, 6, 36'h0, 1, 0, 6, 36'h0);
        // R10: both ports write one word
        step("R10", 1, 1, 4'b0011, 5, 36'h111111111, 1, 1, 5, 36'h222222222);
        step("R10", 1, 0, 4'h0, 5, 36'h0, 1, 0, 5, 36'h0);
        step("R10", 1, 1, 4'b1111, 5, 36'h333333333, 1, 1, 5, 36'h444444444);
        step("R10", 0, 0, 4'h0, 0, 36'h0, 1, 0, 5, 36'h0);
        // R11: read during write to the same word, in both directions
        step("R11", 1, 1, 4'hF, 7, 36'h0F0F0F0F0, 1, 0, 7, 36'h0);
        step("R11", 1, 0, 4'h0, 7, 36'h0, 1, 1, 7, 36'h5A5A5A5A5);
        step("R11", 1, 0, 4'h0, 7, 36'h0, 0, 0, 0, 36'h0);
        // R5: power-down, then reactivation by a read
        idle("R5");
        idle("R5");
        step("R5", 1, 0, 4'h0, 8, 36'h0, 1, 0, 9, 36'h0);
        step("R6", 1, 1, 4'hF, 8, 36'h777777777, 1, 1, 9, 36'h666666666);
        step("R5", 0, 0, 4'h0, 0, 36'h0, 1, 0, 9, 36'h0);
        idle("R5");
        // random traffic over the pool (R2, R3/R4, R9, R10, R11)
        t = pm ? "R4" : "R3";
        for (int k = 0; k < 400; k++) begin
            step(t,
                 $urandom_range(0, 5) != 0, $urandom_range(0, 1) == 1, 4'($urandom_range(0, 15)),
                 pick_addr(), rand_word(),
                 $urandom_range(0, 5) != 0, $urandom_range(0, 1) == 1, pick_addr(), rand_word());
        end
        idle("R2");
        idle("R2");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_mode(1'b0);
        run_mode(1'b1);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule